// File: doc/BRIEF.md
# RDS Bit and Block Position Tracker

This block tracks where a receiver sits inside the framing of a Radio Data System bit stream. One down-counter counts the bits of the current block and a second counts the blocks of the current group. A single-cycle strobe, synchronous to the system clock, marks each received bit. The bit counter steps down on every strobe. Where it would reach zero it reloads at once from a reload value that software can write. That wrap event is the only thing that steps the block counter.

Software reaches the block through a small write port. The port can set the reload value, set the block counter directly, enable each interrupt, and clear each sticky interrupt flag by writing a one. Each counter drives a one-cycle interrupt pulse and a sticky flag. The current counts are always visible. Syndrome checking and interrupt routing are done elsewhere.

Top module: `rds_pos_tracker`

## Requirements
- R1: After reset the bit count is 26, the reload value is 26, the block count is 3, both interrupt enables are off, and all pulses and flags are low.
- R2: A bit strobe while the bit count is above 1 lowers the bit count by one at that clock edge. Without a strobe the bit count holds.
- R3: A bit strobe while the bit count is 1 or 0 is a bit wrap. At the same edge it loads the reload value, with no idle cycle, and it steps the block counter.
- R4: A write to address 0 stores bits [4:0] as the reload value. It leaves the current bit count alone. A wrap in the same cycle loads the old reload value.
- R5: The block counter counts down by one, modulo 4, on each bit wrap, so 0 wraps to 3.
- R6: A write to address 1 loads bits [1:0] into the block counter. It wins over a decrement in the same cycle, and that cycle raises no block event.
- R7: Writing address 2 sets the interrupt enables: bit 0 for the bit interrupt and bit 1 for the block interrupt. An event raises its pulse output for exactly the one cycle after its clock edge, and only if the enable was set before that edge.
- R8: A block event is a bit wrap that moves the block counter from 1 to 0 and is not overridden by a write.
- R9: Each flag is set together with its pulse and then stays set. A write to address 3 clears the flags whose bits are one (bit 0 for the bit flag, bit 1 for the block flag). A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle strobe per received bit |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 reload, 1 block count, 2 enables, 3 flag clear |
| reg_wdata_i | input | 5 | Register write data |
| bit_cnt_o | output | 5 | Current bit count |
| blk_cnt_o | output | 2 | Current block count |
| bit_irq_o | output | 1 | Bit wrap interrupt pulse |
| blk_irq_o | output | 1 | Block event interrupt pulse |
| bit_flag_o | output | 1 | Sticky bit wrap flag |
| blk_flag_o | output | 1 | Sticky block event flag |

## Verification
The assertions assume that the bit strobe and the write strobe are clean single-cycle levels, synchronous to the clock, and that the address is stable whenever a write is made. They allow any reload value from 0 to 31, including 0 and 1, where the counter wraps on every strobe. The stimulus changes inputs only on the falling clock edge. It sweeps every reload value under several strobe patterns. It places block writes, enable changes and flag clears on the same cycles as wraps, so that each priority rule is exercised.

// File: rtl/rds_pos_pkg.sv
package rds_pos_pkg;
  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_BLK    = 2'd1,
    REG_IEN    = 2'd2,
    REG_CLR    = 2'd3
  } reg_sel_e;

  localparam int unsigned IRQ_N   = 2;
  localparam int unsigned IRQ_BIT = 0;
  localparam int unsigned IRQ_BLK = 1;
endpackage

// File: rtl/rds_bit_cnt.sv
module rds_bit_cnt #(
  parameter int unsigned W    = 5,
  parameter int unsigned INIT = 26
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ONE      = W'(1);
  localparam logic [W-1:0] INIT_VAL = W'(INIT);

  logic [W-1:0] cnt_q;

  assign wrap_o = tick_i && (cnt_q <= ONE);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= INIT_VAL;
    else if (tick_i) cnt_q <= (cnt_q <= ONE) ? reload_i : cnt_q - ONE;
  end

  AST_BIT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE); // R2
  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R2
  AST_BIT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q <= ONE) |=> cnt_q == $past(reload_i)); // R3
endmodule

// File: rtl/rds_blk_cnt.sv
module rds_blk_cnt #(
  parameter int unsigned W    = 2,
  parameter int unsigned INIT = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dec_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  localparam logic [W-1:0] ONE      = W'(1);
  localparam logic [W-1:0] INIT_VAL = W'(INIT);

  logic [W-1:0] cnt_q;

  assign zero_o = dec_i && !wr_i && (cnt_q == ONE);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= INIT_VAL;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (dec_i)  cnt_q <= cnt_q - ONE; // wraps modulo 2**W
  end

  AST_BLK_WR_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wdata_i)); // R6
  AST_BLK_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !wr_i) |=> cnt_q == W'($past(cnt_q) - ONE)); // R5
  AST_BLK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_i && !wr_i) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/rds_irq_unit.sv
module rds_irq_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic en_i,
  input  logic clr_i,
  output logic irq_o,
  output logic flag_o
);
  logic irq_q, flag_q;
  logic fire;

  assign fire   = ev_i && en_i;
  assign irq_o  = irq_q;
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      irq_q  <= fire;
      flag_q <= fire || (flag_q && !clr_i); // set beats clear
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ev_i && en_i) |=> !irq_o); // R7
  AST_IRQ_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o); // R9
  AST_FLAG_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(ev_i && en_i)) |=> !flag_o); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o); // R9
endmodule

// File: rtl/rds_pos_tracker.sv
module rds_pos_tracker
  import rds_pos_pkg::*;
#(
  parameter int unsigned BIT_W    = 5,
  parameter int unsigned BLK_W    = 2,
  parameter int unsigned BIT_INIT = 26,
  parameter int unsigned BLK_INIT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_tick_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [BIT_W-1:0] reg_wdata_i,
  output logic [BIT_W-1:0] bit_cnt_o,
  output logic [BLK_W-1:0] blk_cnt_o,
  output logic             bit_irq_o,
  output logic             blk_irq_o,
  output logic             bit_flag_o,
  output logic             blk_flag_o
);
  localparam logic [BIT_W-1:0] RELOAD_INIT = BIT_W'(BIT_INIT);

  reg_sel_e         sel;
  logic [BIT_W-1:0] reload_q;
  logic [IRQ_N-1:0] ien_q;
  logic [IRQ_N-1:0] ev, clr, irq, flag;
  logic             bit_wrap, blk_zero, wr_blk;

  assign sel    = reg_sel_e'(reg_addr_i);
  assign wr_blk = reg_we_i && (sel == REG_BLK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= RELOAD_INIT;
      ien_q    <= '0;
    end else if (reg_we_i) begin
      if (sel == REG_RELOAD) reload_q <= reg_wdata_i;
      if (sel == REG_IEN)    ien_q    <= reg_wdata_i[IRQ_N-1:0];
    end
  end

  rds_bit_cnt #(.W(BIT_W), .INIT(BIT_INIT)) i_bit_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (bit_tick_i),
    .reload_i (reload_q),
    .cnt_o    (bit_cnt_o),
    .wrap_o   (bit_wrap)
  );

  rds_blk_cnt #(.W(BLK_W), .INIT(BLK_INIT)) i_blk_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dec_i   (bit_wrap),
    .wr_i    (wr_blk),
    .wdata_i (reg_wdata_i[BLK_W-1:0]),
    .cnt_o   (blk_cnt_o),
    .zero_o  (blk_zero)
  );

  assign ev[IRQ_BIT] = bit_wrap;
  assign ev[IRQ_BLK] = blk_zero;
  assign clr = (reg_we_i && sel == REG_CLR) ? reg_wdata_i[IRQ_N-1:0] : '0;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_irq
    rds_irq_unit i_irq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ev_i   (ev[g]),
      .en_i   (ien_q[g]),
      .clr_i  (clr[g]),
      .irq_o  (irq[g]),
      .flag_o (flag[g])
    );
  end

  assign bit_irq_o  = irq[IRQ_BIT];
  assign blk_irq_o  = irq[IRQ_BLK];
  assign bit_flag_o = flag[IRQ_BIT];
  assign blk_flag_o = flag[IRQ_BLK];

  AST_BLK_EV_NEEDS_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_zero |-> bit_wrap); // R8
  AST_RELOAD_KEEPS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && sel == REG_RELOAD && !bit_tick_i) |=> $stable(bit_cnt_o)); // R4
  AST_BLK_IRQ_HAS_BIT_EV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_irq_o |-> $past(bit_wrap)); // R8
endmodule

// File: tb/test_rds_pos_tracker.sv
module test_rds_pos_tracker;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_tick_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [4:0] reg_wdata_i = '0;
  logic [4:0] bit_cnt_o;
  logic [1:0] blk_cnt_o;
  logic       bit_irq_o, blk_irq_o, bit_flag_o, blk_flag_o;

  int n_cmp = 0, n_bad = 0;
  int m_bit = 26, m_blk = 3, m_rel = 26, m_en = 0;
  int m_bi = 0, m_ki = 0, m_bf = 0, m_kf = 0;

  always #4 clk = ~clk;

  rds_pos_tracker i_rds_pos_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .bit_tick_i(bit_tick_i), .reg_we_i(reg_we_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .bit_cnt_o(bit_cnt_o),
    .blk_cnt_o(blk_cnt_o), .bit_irq_o(bit_irq_o), .blk_irq_o(blk_irq_o),
    .bit_flag_o(bit_flag_o), .blk_flag_o(blk_flag_o));

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2/R3/R4 bit count", int'(bit_cnt_o), m_bit);
    chk("R5/R6 block count", int'(blk_cnt_o), m_blk);
    chk("R3/R7 bit pulse", int'(bit_irq_o), m_bi);
    chk("R7/R8 block pulse", int'(blk_irq_o), m_ki);
    chk("R9 bit flag", int'(bit_flag_o), m_bf);
    chk("R9 block flag", int'(blk_flag_o), m_kf);
  endtask

  // compare state from the previous edge, then drive this cycle and advance the model
  task automatic cyc(bit tk, bit we, int addr, int data);
    int bz, bw, kz, c;
    @(negedge clk);
    compare();
    bit_tick_i  = tk;
    reg_we_i    = we;
    reg_addr_i  = addr[1:0];
    reg_wdata_i = data[4:0];
    bz = (tk && m_bit <= 1) ? 1 : 0;
    bw = (we && addr == 1) ? 1 : 0;
    kz = (bz && !bw && m_blk == 1) ? 1 : 0;
    if (tk) m_bit = bz ? m_rel : m_bit - 1;
    if (bw) m_blk = data % 4;
    else if (bz) m_blk = (m_blk + 3) % 4;
    m_bi = bz & (m_en % 2);
    m_ki = kz & (m_en / 2);
    c = (we && addr == 3) ? data % 4 : 0;
    m_bf = (m_bi || (m_bf && !(c % 2))) ? 1 : 0;
    m_kf = (m_ki || (m_kf && !(c / 2))) ? 1 : 0;
    if (we && addr == 0) m_rel = data % 32;
    if (we && addr == 2) m_en = data % 4;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog R1: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while reset is held
    chk("R1 reset bit count", int'(bit_cnt_o), 26);
    chk("R1 reset block count", int'(blk_cnt_o), 3);
    chk("R1 reset pulses", int'(bit_irq_o) + int'(blk_irq_o), 0);
    chk("R1 reset flags", int'(bit_flag_o) + int'(blk_flag_o), 0);
    rst_ni = 1'b1;
    // R1: enables off, reload 26; 60 strobes give no pulses
    for (int i = 0; i < 60; i++) cyc(1, 0, 0, 0);
    cyc(0, 1, 2, 3);
    // R2/R3/R5/R8: default reload, strobe every cycle
    for (int i = 0; i < 120; i++) cyc(1, 0, 0, 0);
    // sweep every reload value with mixed strobes and colliding writes
    for (int r = 0; r < 32; r++) begin
      cyc(0, 1, 0, r);
      for (int i = 0; i < 72; i++) begin
        bit tk;
        tk = (i % 3) != 1;
        if (i == 10)      cyc(tk, 1, 0, (r + 7) % 32);   // R4 deferred reload
        else if (i == 20) cyc(1, 1, 1, r % 4);           // R6 write vs decrement
        else if (i == 30) cyc(1, 1, 1, 1);               // R8 arm block event
        else if (i == 40) cyc(tk, 1, 3, 3);              // R9 clear
        else if (i == 50) cyc(tk, 1, 2, r % 4);          // R7 enable mix
        else if (i == 60) cyc(1, 1, 2, 3);
        else              cyc(tk, 0, 0, 0);
      end
    end
    // R3/R6/R9 corner: reload 1 wraps on every strobe
    cyc(0, 1, 0, 1);
    cyc(0, 1, 2, 3);
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(1, 1, 1, 1);   // R6 write wins, no block event
    cyc(1, 0, 0, 0);   // R8 block 1 -> 0 with event
    cyc(1, 1, 3, 3);   // R9 set beats clear on bit flag
    cyc(0, 1, 3, 3);   // R9 clear both
    cyc(0, 0, 0, 0);
    @(negedge clk);
    compare();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule